// File: doc/BRIEF.md
# Depipelined Search-Loop Engine

This block runs the basic block of a pointer-chasing search loop as one macro operator: the key is replaced by `A[B[key]] + x*y + z`, and the loop repeats until the key equals a search value. The arithmetic sits in a single combinational cloud with no pipeline registers. It is allowed several fast-clock cycles to settle. The only datapath registers are the two that capture load results.

A control unit runs on the fast memory clock. For each pass it steps through a fixed series of fast states. It issues the load from array B, waits for its response, then issues the dependent load from array A and waits for that response. It then counts out a parameterised number of settle cycles. It ends the pass with a one-cycle slow enable. That enable writes the live-out key back as the live-in of the next pass. Callers set the operands and base addresses, pulse `start`, and wait for `done`. Operands and bases must stay stable while `busy` is high.

Top module: `sdp_loop_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `slow_en` are low and `key_out` is zero.
- R2: A `start` accepted while idle loads `key_in` into `key_out`. If the key differs from `search`, the next cycle raises `mem_req` with `mem_addr = base_b + 4*key` (modulo 2^AW).
- R3: At most one load is outstanding. After a request, `mem_req` stays low and the engine waits for as many cycles as `mem_rvalid` stays low. It issues nothing and pulses nothing in that time.
- R4: The cycle after the B response, the engine requests `base_a + 4*Bvalue`. Bvalue is the data returned by the B load.
- R5: If the A response is valid in cycle c, `slow_en` is high only in cycle c+SETTLE, for one cycle.
- R6: At the slow enable, `key_out` becomes `Avalue + x*y + z` modulo 2^DW. It does not change in any other busy cycle.
- R7: If the new key differs from `search`, the next B request follows in the cycle right after the slow enable.
- R8: If the new key equals `search`, the engine drops `busy` and raises `done` for exactly one cycle after the slow enable. `key_out` then holds the final key until the next accepted start.
- R9: If `key_in` equals `search` at start, `done` rises in the next cycle and no load is issued.
- R10: `start` is ignored while `busy` is high.
- R11: A `mem_rvalid` arriving when no load is outstanding (settle or idle cycles) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast memory clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin a loop run (idle only) |
| key_in | input | DW | initial key |
| x | input | DW | multiplicand operand |
| y | input | DW | multiplier operand |
| z | input | DW | addend operand |
| search | input | DW | exit value |
| base_a | input | AW | byte base of array A |
| base_b | input | AW | byte base of array B |
| busy | output | 1 | run in progress |
| done | output | 1 | one-cycle exit pulse |
| slow_en | output | 1 | slow enable, one per basic-block pass |
| key_out | output | DW | current / final key |
| mem_req | output | 1 | load request valid |
| mem_addr | output | AW | load byte address |
| mem_rvalid | input | 1 | load response valid |
| mem_rdata | input | DW | load response data |

## Verification
The loop runs over a known 8-step key permutation. Runs exit after one, two and three passes, which separates the loop-back path from the exit path. Memory latencies of 1, 3 and 5 cycles show whether the wait states stretch correctly, and fix the cycle in which the slow enable lands. One run uses bases near the top of the address space and operands whose product overflows, so both address and key arithmetic must wrap. Stray responses during settle and idle cycles, a `start` poked mid-run, and a run whose initial key already matches exercise the paths that must be ignored or skipped.

// File: rtl/sdp_loop_engine.sv
module sdp_loop_engine #(
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter int SETTLE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] key_in,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] z,
  input  logic [DW-1:0] search,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  output logic          busy,
  output logic          done,
  output logic          slow_en,
  output logic [DW-1:0] key_out,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = (SETTLE < 2) ? 1 : $clog2(SETTLE);

  typedef enum logic [2:0] {S_IDLE, S_REQ_B, S_WAIT_B, S_REQ_A, S_WAIT_A, S_SETTLE} st_t;

  st_t           st;
  logic [DW-1:0] key_q, b_q, a_q;
  logic [CW-1:0] cnt;
  logic          done_q;
  logic [DW-1:0] prod, sum;
  logic [AW-1:0] idx;

  assign prod     = x * y;
  assign sum      = a_q + prod + z;
  assign idx      = AW'((st == S_REQ_A) ? b_q : key_q);
  assign mem_req  = (st == S_REQ_B) || (st == S_REQ_A);
  assign mem_addr = ((st == S_REQ_A) ? base_a : base_b) + (idx << 2);
  assign slow_en  = (st == S_SETTLE) && (cnt == CW'(SETTLE - 1));
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign key_out  = key_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      key_q  <= '0;
      b_q    <= '0;
      a_q    <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          key_q <= key_in;
          if (key_in == search) done_q <= 1'b1;
          else                  st     <= S_REQ_B;
        end
        S_REQ_B:  st <= S_WAIT_B;
        S_WAIT_B: if (mem_rvalid) begin
          b_q <= mem_rdata;
          st  <= S_REQ_A;
        end
        S_REQ_A:  st <= S_WAIT_A;
        S_WAIT_A: if (mem_rvalid) begin
          a_q <= mem_rdata;
          cnt <= '0;
          st  <= S_SETTLE;
        end
        S_SETTLE: if (slow_en) begin
          key_q <= sum;
          if (sum == search) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_REQ_B;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdp_loop_engine_chk.sv
module sdp_loop_engine_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW-1:0] key_in,
  input logic [DW-1:0] search,
  input logic          busy,
  input logic          done,
  input logic          slow_en,
  input logic [DW-1:0] key_out,
  input logic          mem_req,
  input logic          mem_rvalid
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n)          pend <= 1'b0;
    else if (mem_req)    pend <= 1'b1;
    else if (mem_rvalid) pend <= 1'b0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !slow_en));
  a_r2_start_req: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && key_in != search) |=> mem_req);
  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !mem_rvalid) |=> !mem_req);
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en |=> !slow_en);
  a_r6_key_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_en && (busy || !start)) |=> $stable(key_out));
  a_r7_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en |=> (done != mem_req));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);
  a_r9_match_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && key_in == search) |=> (done && !mem_req));
endmodule

bind sdp_loop_engine sdp_loop_engine_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in), .search(search),
  .busy(busy), .done(done), .slow_en(slow_en), .key_out(key_out),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid)
);

// File: tb/test_sdp_loop_engine.sv
`timescale 1ns/1ps
module test_sdp_loop_engine;
  localparam int SETTLE = 2;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] key_in = 0, xv = 0, yv = 0, zv = 0, sv = 0, ba = 0, bb = 0;
  logic        busy, done, slow_en, mem_req, rvalid = 0;
  logic [31:0] key_out, mem_addr, rdata = 0;

  always #5 clk = ~clk;

  sdp_loop_engine #(.DW(32), .AW(32), .SETTLE(SETTLE)) i_sdp_loop_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in),
    .x(xv), .y(yv), .z(zv), .search(sv), .base_a(ba), .base_b(bb),
    .busy(busy), .done(done), .slow_en(slow_en), .key_out(key_out),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(rvalid), .mem_rdata(rdata)
  );

  typedef struct packed {
    logic busy, req, slow, done, quiet;
    logic [31:0] addr, key;
  } exp_t;

  exp_t        q[$];
  string       tq[$];
  int          due_q[$];
  logic [31:0] dat_q[$];
  int          n_tests = 0, n_fail = 0, cyc = 0, lat = 1;
  bit          stray_en = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    logic [31:0] ia, ib;
    ia = (a - ba) >> 2;
    ib = (a - bb) >> 2;
    if (ia < 16) return ((7 * ia + 4) % 16) - (xv * yv + zv);
    if (ib < 16) return (5 * ib + 3) % 16;
    return 32'hDEAD_BEEF;
  endfunction

  function automatic logic [31:0] step(input logic [31:0] k);
    logic [31:0] b;
    b = rd(bb + (k << 2));
    return rd(ba + (b << 2)) + xv * yv + zv;
  endfunction

  task automatic push(input bit b, r, s, d, qt, input logic [31:0] a, k, input string t);
    exp_t e;
    e.busy = b; e.req = r; e.slow = s; e.done = d; e.quiet = qt; e.addr = a; e.key = k;
    q.push_back(e);
    tq.push_back(t);
  endtask

  task automatic build_trace(input logic [31:0] k0);
    logic [31:0] k, b;
    bit first;
    k = k0;
    first = 1;
    if (k == sv) begin
      push(0, 0, 0, 1, 1, 0, k, "R9");
    end else begin
      for (int it = 0; it < 40; it++) begin
        push(1, 1, 0, 0, 0, bb + (k << 2), k, first ? "R2" : "R6/R7");
        first = 0;
        repeat (lat) push(1, 0, 0, 0, 0, 0, k, "R3");
        b = rd(bb + (k << 2));
        push(1, 1, 0, 0, 0, ba + (b << 2), k, "R4");
        repeat (lat) push(1, 0, 0, 0, 0, 0, k, "R3");
        repeat (SETTLE - 1) push(1, 0, 0, 0, 1, 0, k, "R11");
        push(1, 0, 1, 0, 1, 0, k, "R5");
        k = rd(ba + (b << 2)) + xv * yv + zv;
        if (k == sv) begin
          push(0, 0, 0, 1, 1, 0, k, "R6/R8");
          break;
        end
      end
    end
    repeat (3) push(0, 0, 0, 0, 1, 0, k, "R8");
  endtask

  always @(negedge clk) begin
    exp_t  e;
    string t;
    bit    qt;
    qt = 0;
    if (rst_n && q.size() > 0) begin
      e  = q.pop_front();
      t  = tq.pop_front();
      qt = e.quiet;
      n_tests++;
      if (busy !== e.busy || mem_req !== e.req || slow_en !== e.slow || done !== e.done ||
          key_out !== e.key || (e.req && mem_addr !== e.addr)) begin
        n_fail++;
        $display("FAIL %s cycle %0d: busy/req/slow/done=%b%b%b%b addr=%h key=%h, expected %b%b%b%b addr=%h key=%h",
                 t, cyc, busy, mem_req, slow_en, done, mem_addr, key_out,
                 e.busy, e.req, e.slow, e.done, e.addr, e.key);
      end
    end
    if (rst_n && mem_req) begin
      due_q.push_back(cyc + lat);
      dat_q.push_back(rd(mem_addr));
    end
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      rvalid = 1;
      rdata  = dat_q.pop_front();
      void'(due_q.pop_front());
    end else if (stray_en && qt) begin
      rvalid = 1;
      rdata  = 32'h5A5A_0000 + cyc;
    end else begin
      rvalid = 0;
    end
    cyc++;
  end

  task automatic run(input logic [31:0] k0, input bit poke);
    @(negedge clk); #1;
    build_trace(k0);
    key_in = k0;
    start  = 1;
    @(negedge clk); #1;
    start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      #1;
      start  = 1;
      key_in = sv;
      @(negedge clk); #1;
      start = 0;
    end
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    n_tests++;
    if (busy !== 0 || done !== 0 || mem_req !== 0 || slow_en !== 0 || key_out !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: busy/done/req/slow=%b%b%b%b key=%h, expected 0000 key=0",
               busy, done, mem_req, slow_en, key_out);
    end

    // one pass, latency 1
    ba = 32'h0000_1000; bb = 32'h0000_2000;
    xv = 3; yv = 4; zv = 5; lat = 1; stray_en = 0;
    sv = step(0);
    run(0, 0);

    // three passes, latency 3, stray responses in settle and idle (R11)
    xv = 32'h0000_0100; yv = 7; zv = 32'hFFFF_FFF0; lat = 3; stray_en = 1;
    sv = step(step(step(4)));
    run(4, 0);

    // two passes, latency 5, wrapping bases and product, start poked while busy (R10)
    ba = 32'hFFFF_FFE0; bb = 32'hFFFF_FF80;
    xv = 32'h0001_0001; yv = 32'h0003_0005; zv = 32'h8000_0000; lat = 5; stray_en = 0;
    sv = step(step(12));
    run(12, 1);

    // immediate exit (R9)
    sv = 5;
    run(5, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: done not reached, expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule